// File: doc/BRIEF.md
# Two-Wire Clocked Wiper Stepper

This block runs the fine-tuning session of a four-channel digital potentiometer. After the command decoder has acknowledged an increment/decrement command, it pulses `arm_i` with the chosen potentiometer on `pot_sel_i`. From then on, every rising edge of the bus clock moves that potentiometer's 8-bit wiper by one position. The step goes up when the bus data line is high during the clock pulse and down when it is low. Up and down pulses may be mixed in any order. A STOP condition on the bus closes the session.

Both bus lines come in asynchronously and pass through a two-flop synchroniser before edge detection. The wiper counters saturate at both ends. The wiper bus seen by the analog side follows the counters through a fixed settling delay of `SETTLE_CYC` clocks. Each accepted clock pulse also produces a one-cycle step event that carries the direction and the potentiometer index. This event is a plain valid strobe with no ready: the step is already applied inside the block, so no back-pressure is possible or needed.

Top module: `wiper_stepper`

## Requirements
- R1: After reset, `active_o` is 0, `step_valid_o` is 0, and every wiper field on `wiper_o` holds `RESET_POS` (128).
- R2: A session starts only on `arm_i` = 1, which latches `pot_sel_i`. While no session is open, bus clock pulses change no wiper and raise no step event.
- R3: In a session, a bus clock rising edge with data high increases the selected wiper by one.
- R4: In a session, a bus clock rising edge with data low decreases the selected wiper by one.
- R5: Only the wiper latched at arm time changes. Changes on `pot_sel_i` during a session are ignored.
- R6: A wiper at 255 stays at 255 on an up step, and a wiper at 0 stays at 0 on a down step. There is no wrap.
- R7: A rising data edge while the clock is high (STOP) ends the session and takes no step. A falling data edge while the clock is high has no effect. Clock pulses after STOP are ignored.
- R8: If the bus clock is first sampled high on clock edge T (data stable around it), the selected counter steps at edge T+2 and `wiper_o` shows it at edge T+2+`SETTLE_CYC`.
- R9: Each accepted step raises `step_valid_o` for exactly one cycle, at edge T+2. In that cycle `step_up_o` = 1 for up and 0 for down, and `step_pot_o` is the latched index.
- R10: Wiper k occupies bits [8k+7:8k] of `wiper_o`.
- R11: `arm_i` during an open session restarts it with the new selection, and it takes priority over a STOP detected in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| arm_i | input | 1 | One-cycle pulse: command acknowledged, open session |
| pot_sel_i | input | 2 | Potentiometer to step, latched on `arm_i` |
| active_o | output | 1 | Session open |
| step_valid_o | output | 1 | One-cycle step event strobe |
| step_up_o | output | 1 | Direction of the step event (1 = up) |
| step_pot_o | output | 2 | Potentiometer of the step event |
| wiper_o | output | 32 | Four settled 8-bit wiper values |

## Verification
A bus clock edge reaches the counters two clocks after it is first sampled: one clock for the synchroniser and one for the edge register. The step strobe appears on that same edge. The wiper bus lags the counters by another `SETTLE_CYC` clocks, and `active_o` follows `arm_i` or a STOP after one and two clocks respectively. The bench keeps a behavioural model that replays the driven line levels through a short history and applies these delays exactly. It compares the session flag, the step event and the whole wiper bus against the design at every falling clock edge, so any result that arrives one cycle early or late is a mismatch.

// File: rtl/wstep_pkg.sv
package wstep_pkg;

  // One sample of the two bus lines.
  typedef struct packed {
    logic scl;
    logic sda;
  } bus_smp_t;

  // Step direction as carried on the event output.
  typedef enum logic {
    STEP_DOWN = 1'b0,
    STEP_UP   = 1'b1
  } step_dir_e;

  // Idle bus level, used as reset value of every bus-side flop.
  localparam bus_smp_t BUS_IDLE = '{scl: 1'b1, sda: 1'b1};

endpackage

// File: rtl/wstep_sync.sv
module wstep_sync
  import wstep_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  bus_smp_t raw_i,
  output bus_smp_t sync_o
);

  bus_smp_t chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= BUS_IDLE;
          else        chain_q[s] <= raw_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= BUS_IDLE;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/wstep_bus_events.sv
module wstep_bus_events
  import wstep_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  bus_smp_t smp_i,
  output logic     clk_rise_o,
  output logic     stop_o,
  output step_dir_e dir_o
);

  bus_smp_t prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= BUS_IDLE;
    else        prev_q <= smp_i;
  end

  // A clock rise is a step request; the data level at that moment gives direction.
  assign clk_rise_o = smp_i.scl & ~prev_q.scl;
  // Data rising while the clock stayed high is the bus STOP.
  assign stop_o     = smp_i.sda & ~prev_q.sda & smp_i.scl & prev_q.scl;
  assign dir_o      = smp_i.sda ? STEP_UP : STEP_DOWN;

  // R7: a STOP and a step request never coincide
  p_stop_not_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(stop_o && clk_rise_o));

endmodule

// File: rtl/wstep_wiper_bank.sv
module wstep_wiper_bank
  import wstep_pkg::*;
#(
  parameter int NUM_POTS  = 4,
  parameter int WIPER_W   = 8,
  parameter int RESET_POS = 128,
  localparam int SEL_W    = (NUM_POTS > 1) ? $clog2(NUM_POTS) : 1,
  localparam int BUS_W    = NUM_POTS * WIPER_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en_i,
  input  step_dir_e        step_dir_i,
  input  logic [SEL_W-1:0] step_sel_i,
  output logic [BUS_W-1:0] cnt_flat_o
);

  localparam logic [WIPER_W-1:0] TOP_POS = {WIPER_W{1'b1}};
  localparam logic [WIPER_W-1:0] BOT_POS = '0;
  localparam logic [WIPER_W-1:0] RST_POS = WIPER_W'(RESET_POS);

  logic [WIPER_W-1:0] cnt_q [NUM_POTS];

  generate
    for (genvar k = 0; k < NUM_POTS; k++) begin : g_pot
      logic hit;
      assign hit = step_en_i && (step_sel_i == SEL_W'(k));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q[k] <= RST_POS;
        end else if (hit) begin
          if (step_dir_i == STEP_UP) begin
            if (cnt_q[k] != TOP_POS) cnt_q[k] <= cnt_q[k] + 1'b1;
          end else begin
            if (cnt_q[k] != BOT_POS) cnt_q[k] <= cnt_q[k] - 1'b1;
          end
        end
      end

      assign cnt_flat_o[k*WIPER_W +: WIPER_W] = cnt_q[k];

      // R3 R4: any change is exactly one position
      p_unit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q[k] != $past(cnt_q[k])) |->
          (cnt_q[k] == WIPER_W'($past(cnt_q[k]) + 1'b1) ||
           cnt_q[k] == WIPER_W'($past(cnt_q[k]) - 1'b1)));

      // R5: only the selected wiper moves
      p_sel_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q[k] != $past(cnt_q[k])) |->
          ($past(step_en_i) && $past(step_sel_i) == SEL_W'(k)));

      // R6: no wrap at the top
      p_sat_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && step_dir_i == STEP_UP && cnt_q[k] == TOP_POS) |=> (cnt_q[k] == TOP_POS));

      // R6: no wrap at the bottom
      p_sat_bot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && step_dir_i == STEP_DOWN && cnt_q[k] == BOT_POS) |=> (cnt_q[k] == BOT_POS));
    end
  endgenerate

endmodule

// File: rtl/wstep_settle.sv
module wstep_settle #(
  parameter int               WIDTH   = 32,
  parameter int               DEPTH   = 3,
  parameter logic [WIDTH-1:0] RST_VEC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  generate
    if (DEPTH == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_line
      logic [WIDTH-1:0] stage_q [DEPTH];
      for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_head
          always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VEC;
            else        stage_q[s] <= d_i;
          end
        end else begin : g_tail
          always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VEC;
            else        stage_q[s] <= stage_q[s-1];
          end
        end
      end
      assign q_o = stage_q[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/wiper_stepper.sv
module wiper_stepper
  import wstep_pkg::*;
#(
  parameter int NUM_POTS   = 4,
  parameter int WIPER_W    = 8,
  parameter int SETTLE_CYC = 3,
  parameter int RESET_POS  = 128,
  localparam int SEL_W     = (NUM_POTS > 1) ? $clog2(NUM_POTS) : 1,
  localparam int BUS_W     = NUM_POTS * WIPER_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             arm_i,
  input  logic [SEL_W-1:0] pot_sel_i,
  output logic             active_o,
  output logic             step_valid_o,
  output logic             step_up_o,
  output logic [SEL_W-1:0] step_pot_o,
  output logic [BUS_W-1:0] wiper_o
);

  localparam logic [BUS_W-1:0] WIPER_RST = {NUM_POTS{WIPER_W'(RESET_POS)}};

  bus_smp_t         raw_smp, sync_smp;
  logic             clk_rise, stop_seen, step_go;
  step_dir_e        dir;
  logic             active_q;
  logic [SEL_W-1:0] sel_q;
  logic [BUS_W-1:0] cnt_flat;

  assign raw_smp.scl = scl_i;
  assign raw_smp.sda = sda_i;

  wstep_sync #(.STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (raw_smp),
    .sync_o (sync_smp)
  );

  wstep_bus_events u_events (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_i      (sync_smp),
    .clk_rise_o (clk_rise),
    .stop_o     (stop_seen),
    .dir_o      (dir)
  );

  // Session control: arm wins over a simultaneous STOP.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sel_q    <= '0;
    end else if (arm_i) begin
      active_q <= 1'b1;
      sel_q    <= pot_sel_i;
    end else if (stop_seen) begin
      active_q <= 1'b0;
    end
  end

  assign step_go = active_q && clk_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_valid_o <= 1'b0;
      step_up_o    <= 1'b0;
      step_pot_o   <= '0;
    end else begin
      step_valid_o <= step_go;
      step_up_o    <= (dir == STEP_UP);
      step_pot_o   <= sel_q;
    end
  end

  wstep_wiper_bank #(
    .NUM_POTS  (NUM_POTS),
    .WIPER_W   (WIPER_W),
    .RESET_POS (RESET_POS)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_en_i  (step_go),
    .step_dir_i (dir),
    .step_sel_i (sel_q),
    .cnt_flat_o (cnt_flat)
  );

  wstep_settle #(
    .WIDTH   (BUS_W),
    .DEPTH   (SETTLE_CYC),
    .RST_VEC (WIPER_RST)
  ) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cnt_flat),
    .q_o   (wiper_o)
  );

  assign active_o = active_q;

  // R2: arm opens the session on the next edge
  p_arm_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> active_q);

  // R7: STOP without arm closes the session
  p_stop_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_seen && !arm_i) |=> !active_q);

  // R9: a step event needs an open session in the cycle before
  p_event_in_session_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid_o |-> $past(active_q));

  // R9: events last one cycle (clock rises are at least two cycles apart)
  p_event_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid_o |=> !step_valid_o);

endmodule

// File: tb/wiper_stepper_test.sv
module wiper_stepper_test;

  localparam int NP  = 4;
  localparam int WW  = 8;
  localparam int D   = 3;
  localparam int BW  = NP * WW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          scl = 1'b1, sda = 1'b1, arm = 1'b0;
  logic [1:0]    psel = 2'd0;
  logic          active, sv, sup;
  logic [1:0]    spot;
  logic [BW-1:0] wip;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wiper_stepper #(.NUM_POTS(NP), .WIPER_W(WW), .SETTLE_CYC(D), .RESET_POS(128)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .arm_i(arm),
    .pot_sel_i(psel), .active_o(active), .step_valid_o(sv), .step_up_o(sup),
    .step_pot_o(spot), .wiper_o(wip)
  );

  // Behavioural reference: line history, session state, wiper values.
  bit            hs [4], hd [4];
  bit            m_act, e_sv, e_up;
  int            m_pot, e_pot;
  int            mw [NP];
  logic [BW-1:0] hist [D+1];

  function automatic logic [BW-1:0] pack_model();
    logic [BW-1:0] v;
    for (int k = 0; k < NP; k++) v[k*WW +: WW] = WW'(mw[k]);
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin hs[i] = 1; hd[i] = 1; end
      m_act = 0; m_pot = 0; e_sv = 0; e_up = 0; e_pot = 0;
      for (int k = 0; k < NP; k++) mw[k] = 128;
      for (int i = 0; i <= D; i++) hist[i] = pack_model();
    end else begin
      bit stepnow, stopnow;
      for (int i = 3; i > 0; i--) begin hs[i] = hs[i-1]; hd[i] = hd[i-1]; end
      hs[0] = scl; hd[0] = sda;
      stepnow = m_act && hs[2] && !hs[3];
      stopnow = hd[2] && !hd[3] && hs[2] && hs[3];
      e_sv = stepnow;
      if (stepnow) begin
        e_up = hd[2]; e_pot = m_pot;
        if (hd[2] && mw[m_pot] < 255) mw[m_pot]++;
        if (!hd[2] && mw[m_pot] > 0) mw[m_pot]--;
      end
      if (arm) begin m_act = 1; m_pot = int'(psel); end
      else if (stopnow) m_act = 0;
      for (int i = D; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = pack_model();
    end
  end

  task automatic chk(string req, logic [BW-1:0] act, logic [BW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 R7 R11 active", BW'(active), BW'(m_act));
      chk("R9 step_valid", BW'(sv), BW'(e_sv));
      if (e_sv) begin
        chk("R9 step_up", BW'(sup), BW'(e_up));
        chk("R9 step_pot", BW'(spot), BW'(e_pot));
      end
      chk("R3 R4 R5 R6 R8 R10 wiper", wip, hist[D]);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // Clock pulse: lower clock, set data, raise clock; clock is left high.
  task automatic pulse(bit up);
    scl = 0; tick(2);
    sda = up; tick(2);
    scl = 1; tick(2);
  endtask

  // STOP from a high clock: drop data if needed, then raise it.
  task automatic stop_bus();
    if (sda) begin sda = 0; tick(3); end
    sda = 1; tick(3);
  endtask

  task automatic arm_pot(int p);
    psel = 2'(p); arm = 1; tick(1); arm = 0;
  endtask

  task automatic summary();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual timeout expected completion");
    summary();
  end

  initial begin
    tick(5);
    rst_n = 1;
    tick(1);
    // R1 reset state
    chk("R1 active", BW'(active), '0);
    chk("R1 step_valid", BW'(sv), '0);
    chk("R1 wiper", wip, {NP{8'd128}});

    // R2: pulses with no session do nothing
    pulse(1); pulse(0); pulse(1);
    tick(8);
    chk("R2 idle wiper", wip, {NP{8'd128}});

    // R3 R4 R5: mixed session on pot 1, selection changed mid-way
    arm_pot(1);
    repeat (5) pulse(1);
    repeat (3) pulse(0);
    pulse(1);
    psel = 2'd3;
    pulse(1); pulse(1);
    stop_bus();
    tick(D + 4);
    chk("R5 R10 pot1", BW'(wip[15:8]), BW'(133));
    chk("R5 R10 pot3", BW'(wip[31:24]), BW'(128));

    // R7: pulses after STOP ignored
    pulse(1); pulse(0); pulse(1);
    tick(D + 4);
    chk("R7 pot1 held", BW'(wip[15:8]), BW'(133));

    // R6: saturate low on pot 0
    arm_pot(0);
    repeat (135) pulse(0);
    stop_bus();
    tick(D + 4);
    chk("R6 pot0 floor", BW'(wip[7:0]), BW'(0));

    // R6: saturate high on pot 3
    arm_pot(3);
    repeat (130) pulse(1);
    tick(D + 4);
    chk("R6 pot3 ceiling", BW'(wip[31:24]), BW'(255));

    // R11: re-arm to pot 2 while session open
    arm_pot(2);
    pulse(1); pulse(1);
    stop_bus();
    tick(D + 4);
    chk("R11 pot2", BW'(wip[23:16]), BW'(130));
    chk("R11 pot3 unchanged", BW'(wip[31:24]), BW'(255));
    chk("R7 closed", BW'(active), '0);

    summary();
  end

endmodule